// File: doc/BRIEF.md
# Sector Rewrite Sequencer for Block-Erased Non-Volatile Memory

This block changes one word of a non-volatile memory that can only be erased a whole sector at a time and whose program operation can only clear bits. A client hands it a word address and a new value. The block then runs four phases. It copies every word of the containing sector into an internal scratch RAM. It erases the sector. It places the new value into the scratch copy. Finally it programs the scratch copy back into the memory one word at a time.

Every erase and every program reaches the memory as a fixed run of bus writes on consecutive cycles: two unlock writes, a setup write, and then either a program write or a second unlock pair followed by a confirm write. After the last write of a run, the memory takes a long, variable time to finish. The block holds off all further bus traffic until the memory's ready line returns high. If ready stays low for too long, the block raises an error flag and abandons the update.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While an update is in progress, `req_ready` stays low, so the client must hold `req_valid`, `req_addr` and `req_data` steady until acceptance. The block has no outgoing data stream. Completion is reported by a one-cycle `done` pulse, and an abort is reported by `err`.

Top module: `sector_rewrite_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `fl_rd` and `fl_wr` are low and `req_ready` is high. `req_ready` is high exactly when the block is idle. A request is accepted on an edge with `req_valid` and `req_ready` both high, and `busy` is high from the following cycle until the update ends. A request held while busy is not taken until the block is idle again.
- R2: The copy phase reads the sector base (request address with its low log2(SECT_WORDS) bits cleared) and then each following word in ascending order. There is one `fl_rd` per cycle, exactly SECT_WORDS reads are made, and read data is taken one cycle after its strobe.
- R3: `fl_rd` and `fl_wr` are never high in the same cycle.
- R4: An erase is six writes on consecutive cycles: 0xAA to UNLOCK_A1, 0x55 to UNLOCK_A2, 0x80 to UNLOCK_A1, 0xAA to UNLOCK_A1, 0x55 to UNLOCK_A2, then 0x30 to the sector base. Exactly one erase is issued per successful update.
- R5: A program is four writes on consecutive cycles: 0xAA to UNLOCK_A1, 0x55 to UNLOCK_A2, 0xA0 to UNLOCK_A1, then the word value to the word address.
- R6: After the last write of an erase or program, the block makes no read or write until `fl_ready` is high again. Each command begins only while `fl_ready` is high.
- R7: After a successful update, the target word holds the new value. Every other word of its sector holds its earlier value, and words in other sectors are unchanged.
- R8: With SKIP_ERASED set (the default), a scratch word equal to all ones is not programmed. An all-ones word in the erased sector already holds that value.
- R9: If `fl_ready` stays low for TIMEOUT_CYC cycles while a command is being waited on, `err` goes high and the block returns to idle with no further bus writes. `err` stays high until the next request is accepted.
- R10: `done` is a single-cycle pulse at the end of a successful update, and `busy` is low in the next cycle.
- R11: No program command is issued for a sector until the erase of that sector in the same update has completed. Every program therefore only clears bits of an erased word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Word address to change |
| req_data | input | DATA_W | New word value |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse on successful finish |
| err | output | 1 | Busy-wait timeout, update abandoned |
| fl_rd | output | 1 | Memory read strobe |
| fl_wr | output | 1 | Memory write strobe |
| fl_addr | output | ADDR_W | Memory word address |
| fl_wdata | output | DATA_W | Memory write data |
| fl_rdata | input | DATA_W | Read data, valid the cycle after `fl_rd` |
| fl_ready | input | 1 | Memory idle; low while erasing or programming |

## Verification
The assertions on command timing take for granted that the memory's `fl_ready` is high whenever a command run begins. They also take for granted that `fl_ready` drops in the cycle after the last write of a run and rises again only once the operation is over. The bench's behavioural memory follows that rule with programmable erase and program busy times. After the deliberately forced timeout, the bench waits for `fl_ready` before presenting the next request, so that request never starts against a memory that is still busy. The client side is assumed to keep request fields steady while `req_valid` is high and unaccepted, and the back-pressure scenario holds them that way.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {CMD_ERASE, CMD_PROG} cmd_kind_t;

  typedef enum logic [1:0] {C_IDLE, C_ISSUE, C_GUARD, C_POLL} cmd_state_t;

  typedef enum logic [2:0] {
    S_IDLE, S_COPY, S_ERS_GO, S_ERS_WAIT, S_MERGE, S_PRG_SCAN, S_PRG_WAIT, S_FINISH
  } rw_state_t;
endpackage

// File: rtl/srs_scratch.sv
module srs_scratch #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  assign rdata_o = store[raddr_i];
endmodule

// File: rtl/srs_cmd_seq.sv
module srs_cmd_seq import srs_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int TIMEOUT_CYC = 1024,
  parameter logic [ADDR_W-1:0] UNLOCK_A1   = 'h55,
  parameter logic [ADDR_W-1:0] UNLOCK_A2   = 'h2A,
  parameter logic [DATA_W-1:0] KEY1        = 'hAA,
  parameter logic [DATA_W-1:0] KEY2        = 'h55,
  parameter logic [DATA_W-1:0] ERS_SETUP   = 'h80,
  parameter logic [DATA_W-1:0] ERS_CONFIRM = 'h30,
  parameter logic [DATA_W-1:0] PRG_SETUP   = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  cmd_kind_t         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fl_ready_i,
  output logic              fl_wr_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  output logic              done_o,
  output logic              tmo_o
);
  localparam int WC_W = $clog2(TIMEOUT_CYC + 1);

  cmd_state_t        st_q;
  cmd_kind_t         kind_q;
  logic [2:0]        step_q;
  logic [2:0]        last_step;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [WC_W-1:0]   wcnt_q;
  logic              wait_end;

  assign last_step = (kind_q == CMD_ERASE) ? 3'd5 : 3'd3;
  assign wait_end  = (wcnt_q == WC_W'(TIMEOUT_CYC - 1));

  // step table: unlock pair, setup, then payload (erase repeats the unlock pair)
  always_comb begin
    fl_addr_o  = UNLOCK_A1;
    fl_wdata_o = KEY1;
    if (kind_q == CMD_ERASE) begin
      case (step_q)
        3'd0:    begin fl_addr_o = UNLOCK_A1; fl_wdata_o = KEY1;        end
        3'd1:    begin fl_addr_o = UNLOCK_A2; fl_wdata_o = KEY2;        end
        3'd2:    begin fl_addr_o = UNLOCK_A1; fl_wdata_o = ERS_SETUP;   end
        3'd3:    begin fl_addr_o = UNLOCK_A1; fl_wdata_o = KEY1;        end
        3'd4:    begin fl_addr_o = UNLOCK_A2; fl_wdata_o = KEY2;        end
        default: begin fl_addr_o = addr_q;    fl_wdata_o = ERS_CONFIRM; end
      endcase
    end else begin
      case (step_q)
        3'd0:    begin fl_addr_o = UNLOCK_A1; fl_wdata_o = KEY1;      end
        3'd1:    begin fl_addr_o = UNLOCK_A2; fl_wdata_o = KEY2;      end
        3'd2:    begin fl_addr_o = UNLOCK_A1; fl_wdata_o = PRG_SETUP; end
        default: begin fl_addr_o = addr_q;    fl_wdata_o = data_q;    end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      kind_q <= CMD_ERASE;
      step_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        C_IDLE: if (start_i) begin
          st_q   <= C_ISSUE;
          step_q <= '0;
          kind_q <= kind_i;
          addr_q <= addr_i;
          data_q <= data_i;
        end
        C_ISSUE: begin
          if (step_q == last_step) st_q <= C_GUARD;
          else                     step_q <= step_q + 3'd1;
        end
        C_GUARD: begin
          st_q   <= C_POLL;
          wcnt_q <= '0;
        end
        C_POLL: begin
          if (fl_ready_i || wait_end) st_q <= C_IDLE;
          else                        wcnt_q <= wcnt_q + WC_W'(1);
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign fl_wr_o = (st_q == C_ISSUE);
  assign done_o  = (st_q == C_POLL) && fl_ready_i;
  assign tmo_o   = (st_q == C_POLL) && !fl_ready_i && wait_end;

  // R6: a command run only begins against an idle memory
  p_cmd_begin_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_wr_o && step_q == 3'd0) |-> fl_ready_i);
  // R6: the owner never restarts the sequencer in mid-command
  p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (st_q == C_IDLE));
  // R6: completion reported only with the memory ready, and bus quiet next
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !fl_wr_o);
endmodule

// File: rtl/sector_rewrite_seq.sv
module sector_rewrite_seq import srs_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int SECT_WORDS  = 16,
  parameter int TIMEOUT_CYC = 1024,
  parameter bit SKIP_ERASED = 1'b1,
  parameter logic [ADDR_W-1:0] UNLOCK_A1   = 'h55,
  parameter logic [ADDR_W-1:0] UNLOCK_A2   = 'h2A,
  parameter logic [DATA_W-1:0] KEY1        = 'hAA,
  parameter logic [DATA_W-1:0] KEY2        = 'h55,
  parameter logic [DATA_W-1:0] ERS_SETUP   = 'h80,
  parameter logic [DATA_W-1:0] ERS_CONFIRM = 'h30,
  parameter logic [DATA_W-1:0] PRG_SETUP   = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fl_rd,
  output logic              fl_wr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_ready
);
  localparam int OFF_W = $clog2(SECT_WORDS);
  localparam int SEC_W = ADDR_W - OFF_W;
  localparam int IDX_W = OFF_W + 1;

  rw_state_t         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SEC_W-1:0]  sect_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic              erased_q, erased_d;
  logic              err_q, err_d;
  logic              accept;
  logic              idx_end;

  logic              scr_we;
  logic [OFF_W-1:0]  scr_waddr;
  logic [DATA_W-1:0] scr_wdata;
  logic [DATA_W-1:0] scr_rdata;
  logic              blank;

  logic              seq_start;
  cmd_kind_t         seq_kind;
  logic [ADDR_W-1:0] seq_addr;
  logic              seq_wr;
  logic [ADDR_W-1:0] seq_fl_addr;
  logic              seq_done;
  logic              seq_tmo;

  assign accept  = req_valid && req_ready;
  assign idx_end = (idx_q == IDX_W'(SECT_WORDS));

  srs_scratch #(.DEPTH(SECT_WORDS), .DATA_W(DATA_W)) u_scratch (
    .clk     (clk),
    .we_i    (scr_we),
    .waddr_i (scr_waddr),
    .wdata_i (scr_wdata),
    .raddr_i (idx_q[OFF_W-1:0]),
    .rdata_o (scr_rdata)
  );

  srs_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC),
    .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2), .KEY1(KEY1), .KEY2(KEY2),
    .ERS_SETUP(ERS_SETUP), .ERS_CONFIRM(ERS_CONFIRM), .PRG_SETUP(PRG_SETUP)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (seq_start),
    .kind_i     (seq_kind),
    .addr_i     (seq_addr),
    .data_i     (scr_rdata),
    .fl_ready_i (fl_ready),
    .fl_wr_o    (seq_wr),
    .fl_addr_o  (seq_fl_addr),
    .fl_wdata_o (fl_wdata),
    .done_o     (seq_done),
    .tmo_o      (seq_tmo)
  );

  // variant: skip programming words that already read as erased
  generate
    if (SKIP_ERASED) begin : g_skip
      assign blank = &scr_rdata;
    end else begin : g_noskip
      assign blank = 1'b0;
    end
  endgenerate

  // scratch fill: copy data lands one cycle after its read; merge overwrites
  always_comb begin
    scr_we    = 1'b0;
    scr_waddr = idx_q[OFF_W-1:0] - OFF_W'(1);
    scr_wdata = fl_rdata;
    if (st_q == S_COPY && idx_q != '0) begin
      scr_we = 1'b1;
    end else if (st_q == S_MERGE) begin
      scr_we    = 1'b1;
      scr_waddr = off_q;
      scr_wdata = data_q;
    end
  end

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    erased_d  = erased_q;
    err_d     = err_q;
    seq_start = 1'b0;
    seq_kind  = CMD_ERASE;
    seq_addr  = {sect_q, {OFF_W{1'b0}}};
    done      = 1'b0;
    case (st_q)
      S_IDLE: if (accept) begin
        st_d     = S_COPY;
        idx_d    = '0;
        err_d    = 1'b0;
        erased_d = 1'b0;
      end
      S_COPY: begin
        if (idx_end) begin
          st_d  = S_ERS_GO;
          idx_d = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      S_ERS_GO: begin
        seq_start = 1'b1;
        st_d      = S_ERS_WAIT;
      end
      S_ERS_WAIT: begin
        if (seq_done) begin
          st_d     = S_MERGE;
          erased_d = 1'b1;
        end else if (seq_tmo) begin
          st_d  = S_IDLE;
          err_d = 1'b1;
        end
      end
      S_MERGE: begin
        st_d  = S_PRG_SCAN;
        idx_d = '0;
      end
      S_PRG_SCAN: begin
        seq_kind = CMD_PROG;
        seq_addr = {sect_q, idx_q[OFF_W-1:0]};
        if (idx_end) begin
          st_d = S_FINISH;
        end else if (blank) begin
          idx_d = idx_q + IDX_W'(1);
        end else begin
          seq_start = 1'b1;
          st_d      = S_PRG_WAIT;
        end
      end
      S_PRG_WAIT: begin
        seq_kind = CMD_PROG;
        if (seq_done) begin
          st_d  = S_PRG_SCAN;
          idx_d = idx_q + IDX_W'(1);
        end else if (seq_tmo) begin
          st_d  = S_IDLE;
          err_d = 1'b1;
        end
      end
      S_FINISH: begin
        done     = 1'b1;
        erased_d = 1'b0;
        st_d     = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      sect_q   <= '0;
      off_q    <= '0;
      data_q   <= '0;
      erased_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      erased_q <= erased_d;
      err_q    <= err_d;
      if (accept) begin
        sect_q <= req_addr[ADDR_W-1:OFF_W];
        off_q  <= req_addr[OFF_W-1:0];
        data_q <= req_data;
      end
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign busy      = (st_q != S_IDLE);
  assign err       = err_q;
  assign fl_rd     = (st_q == S_COPY) && !idx_end;
  assign fl_wr     = seq_wr;
  assign fl_addr   = (st_q == S_COPY) ? {sect_q, idx_q[OFF_W-1:0]} : seq_fl_addr;

  // R1: acceptance turns the block busy in the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R1: a request cannot be taken while an update runs
  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  // R3: one bus direction per cycle
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_rd && fl_wr));
  // R2: copy reads never leave the latched sector
  p_rd_in_sector_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> (fl_addr[ADDR_W-1:OFF_W] == sect_q));
  // R11: program commands only after this update's erase has finished
  p_prog_after_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && seq_kind == CMD_PROG) |-> erased_q);
  // R10: done is a single pulse followed by idle
  p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  // R9: a raised error means the update has been abandoned
  p_err_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!busy && $past(seq_tmo)));
endmodule

// File: tb/sector_rewrite_seq_test.sv
module sector_rewrite_seq_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NS = 16;
  localparam logic [AW-1:0] A1 = 8'h55;
  localparam logic [AW-1:0] A2 = 8'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, busy, done, err, fl_rd, fl_wr, fl_ready;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sector_rewrite_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_WORDS(NS), .TIMEOUT_CYC(300)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .err(err),
    .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_ready(fl_ready)
  );

  // behavioural sector-erased memory
  logic [DW-1:0] fmem [256];
  logic [DW-1:0] exp_mem [256];
  logic [AW-1:0] rd_log [256];
  int busy_cnt = 0;
  int prog_time = 20;
  int erase_time = 150;
  int cst = 0;
  int n_rd = 0, n_wr = 0, n_prog = 0, n_erase = 0;
  int seq_bad = 0, bit_bad = 0, acc_bad = 0;
  logic [AW-1:0] last_erase = '0;

  assign fl_ready = (busy_cnt == 0);

  always @(posedge clk) begin
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if ((fl_rd || fl_wr) && busy_cnt != 0) acc_bad <= acc_bad + 1;
    if (fl_rd) begin
      fl_rdata <= fmem[fl_addr];
      rd_log[n_rd[7:0]] <= fl_addr;
      n_rd <= n_rd + 1;
    end
    if (fl_wr) begin
      n_wr <= n_wr + 1;
      case (cst)
        0: cst <= (fl_addr == A1 && fl_wdata == 16'hAA) ? 1 : 0;
        1: cst <= (fl_addr == A2 && fl_wdata == 16'h55) ? 2 : 0;
        2: cst <= (fl_addr == A1 && fl_wdata == 16'hA0) ? 3 :
                  (fl_addr == A1 && fl_wdata == 16'h80) ? 4 : 0;
        3: begin
          if ((fmem[fl_addr] & fl_wdata) != fl_wdata) bit_bad <= bit_bad + 1;
          fmem[fl_addr] <= fmem[fl_addr] & fl_wdata;
          busy_cnt <= prog_time;
          n_prog <= n_prog + 1;
          cst <= 0;
        end
        4: cst <= (fl_addr == A1 && fl_wdata == 16'hAA) ? 5 : 0;
        5: cst <= (fl_addr == A2 && fl_wdata == 16'h55) ? 6 : 0;
        default: begin
          if (fl_wdata == 16'h30) begin
            for (int k = 0; k < NS; k++) fmem[{fl_addr[7:4], k[3:0]}] <= 16'hFFFF;
            busy_cnt <= erase_time;
            n_erase <= n_erase + 1;
            last_erase <= fl_addr;
          end
          cst <= 0;
        end
      endcase
      if ((cst == 0 && !(fl_addr == A1 && fl_wdata == 16'hAA)) ||
          (cst == 1 && !(fl_addr == A2 && fl_wdata == 16'h55)) ||
          (cst == 2 && !(fl_addr == A1 && (fl_wdata == 16'hA0 || fl_wdata == 16'h80))) ||
          (cst == 4 && !(fl_addr == A1 && fl_wdata == 16'hAA)) ||
          (cst == 5 && !(fl_addr == A2 && fl_wdata == 16'h55)) ||
          (cst == 6 && fl_wdata != 16'h30))
        seq_bad <= seq_bad + 1;
    end else if (cst != 0) begin
      seq_bad <= seq_bad + 1;   // gap inside a command run
      cst <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic send_req(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_addr  = a;
    req_data  = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(done, req, "done pulse seen", done, 1);
    @(negedge clk);
    chk(!done && !busy, "R10", "done single cycle then idle", {done, busy}, 0);
  endtask

  task automatic mem_compare(input string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (fmem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, req, "memory words mismatching", mism, 0);
  endtask

  function automatic int live_words(input logic [AW-1:0] a);
    int c = 0;
    for (int k = 0; k < NS; k++) if (exp_mem[{a[7:4], k[3:0]}] != 16'hFFFF) c++;
    return c;
  endfunction

  // one full update with all its checks
  task automatic t_update(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int rd0 = n_rd, pr0 = n_prog, er0 = n_erase, sb0 = seq_bad, bb0 = bit_bad, ab0 = acc_bad;
    int rbad = 0;
    logic [AW-1:0] base = {a[7:4], 4'h0};
    send_req(a, d);
    req_valid = 1'b0;
    chk(busy, "R1", "busy after accept", busy, 1);
    chk(!req_ready, "R1", "ready low while busy", req_ready, 0);
    chk(!err, "R9", "err cleared on acceptance", err, 0);
    exp_mem[a] = d;
    wait_done("R10");
    chk(n_rd - rd0 == NS, "R2", "copy read count", n_rd - rd0, NS);
    for (int k = 0; k < NS; k++)
      if (rd_log[(rd0 + k) & 255] != base + AW'(k)) rbad++;
    chk(rbad == 0, "R2", "reads out of order", rbad, 0);
    chk(n_erase - er0 == 1, "R4", "erase count", n_erase - er0, 1);
    chk(last_erase == base, "R4", "erase address", last_erase, base);
    chk(seq_bad == sb0, "R5", "malformed command runs", seq_bad - sb0, 0);
    chk(n_prog - pr0 == live_words(a), "R8", "program count", n_prog - pr0, live_words(a));
    chk(acc_bad == ab0, "R6", "accesses while memory busy", acc_bad - ab0, 0);
    chk(bit_bad == bb0, "R11", "programs setting bits", bit_bad - bb0, 0);
    mem_compare("R7");
  endtask

  task automatic t_reset;
    chk(!busy, "R1", "reset busy", busy, 0);
    chk(req_ready, "R1", "reset ready", req_ready, 1);
    chk(!err, "R1", "reset err", err, 0);
    chk(!done, "R1", "reset done", done, 0);
    chk(!fl_rd && !fl_wr, "R3", "reset strobes", {fl_rd, fl_wr}, 0);
  endtask

  task automatic t_backpressure;
    int taken = 0;
    int er0 = n_erase;
    send_req(8'h41, 16'h0F0F);
    exp_mem[8'h41] = 16'h0F0F;
    req_addr = 8'h44;
    req_data = 16'h7777;
    while (!done) begin
      if (req_ready) taken++;
      @(negedge clk);
    end
    chk(taken == 0, "R1", "held request taken while busy", taken, 0);
    @(negedge clk);
    chk(req_ready && req_valid, "R1", "held request offered when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R1", "held request accepted", busy, 1);
    exp_mem[8'h44] = 16'h7777;
    wait_done("R10");
    chk(n_erase - er0 == 2, "R4", "two erases for two updates", n_erase - er0, 2);
    mem_compare("R7");
  endtask

  task automatic t_timeout;
    int w0 = n_wr, p0 = n_prog, k = 0;
    erase_time = 2000;
    send_req(8'h50, 16'h1111);
    req_valid = 1'b0;
    while (!err && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(err, "R9", "err after stuck erase", err, 1);
    chk(!busy && req_ready, "R9", "idle after abort", busy, 0);
    repeat (10) @(negedge clk);
    chk(n_wr - w0 == 6, "R9", "writes after abort", n_wr - w0, 6);
    chk(n_prog == p0, "R9", "programs after abort", n_prog - p0, 0);
    chk(err, "R9", "err held until next request", err, 1);
    while (!fl_ready) @(negedge clk);
    erase_time = 150;
    for (int i = 0; i < NS; i++) exp_mem[8'h50 + i] = 16'hFFFF;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      fmem[i] = ((i % 5) == 3) ? 16'hFFFF : (16'(i) * 16'h9E37) ^ 16'h5A5A;
      exp_mem[i] = fmem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_update(8'h23, 16'h1234);   // mid sector, blanks present
    t_update(8'h00, 16'h0000);   // first word of first sector
    t_update(8'hFF, 16'hFFFF);   // last word, all-ones value skipped
    t_update(8'h26, 16'hA5A5);   // same sector again
    t_backpressure();
    t_timeout();
    t_update(8'h70, 16'h00F0);   // recovery, err clears
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule